// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block sits beside the trap logic of a 32-bit processor pipeline. When the pipeline accepts an exception it presents the exception kind, the faulting PC, the branch-delay flag and a snapshot of the relevant status and cause state for one cycle. One cycle later the block returns four things: the handler entry PC, the updated cause register value, the saved return PC, and one-cycle pulses that tell the status register which of its exception bits to set.

The handler address is a base plus an offset. The base is either the fixed boot base or the software-programmed exception base, aligned down. The offset depends on several things: whether the exception is a TLB refill, whether an exception is already in progress, vectored-interrupt spacing (with the highest-priority enabled pending line selecting the vector), and the special placement of the cache-error vector. Non-maskable interrupts and soft resets use a separate path. They save their return PC in the error return register, request the error and boot-vector status bits, and jump to the fixed reset vector. An exception kind outside the supported set raises an error pulse and changes nothing else.

Top module: `exc_vec_ctrl`

## Requirements
- R1: After reset, `take`, `type_err` and every write/set strobe are low.
- R2: An accepted request (`exc_valid` high at a rising edge) gives its result on the outputs after that edge, with `take` high for exactly one cycle. A kind outside the supported set instead pulses `type_err` for one cycle, with `take` and all write/set strobes low.
- R3: The kind encoding equals the exception code for the ordinary kinds: 0 interrupt, 1 modify, 2 TLB load, 3 TLB store, 4/5 address error load/store, 6/7 instruction/data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 floating point, 19 read-inhibit, 20 execute-inhibit, 30 cache error. Kind 16 is NMI and kind 17 is soft reset. For an ordinary kind, `cause_we` is high and `cause_out[6:2]` holds the code.
- R4: On a cause write, every bit of `cause_out` except bits [6:2] and bit 31 (branch-delay flag) equals `cause_in`.
- R5: Handler PC = base + offset. The base is 0xBFC00200 when BEV is set. Otherwise it is `exc_base` with bits [9:0] cleared. The default offset is 0x180.
- R6: A TLB load or store (kinds 2, 3) with `exc_refill` high and EXL clear uses offset 0x000. With EXL set it uses 0x180.
- R7: An interrupt with IV clear uses 0x180. With IV set, it uses 0x200 if BEV is set or the spacing is zero. Otherwise it uses 0x200 + v × (spacing × 32), where v is the index of the highest set bit of `cause_ip & st_im` (0 if none).
- R8: A cache error (kind 30) uses offset 0x100 with BEV set and 0x20000100 with BEV clear.
- R9: For an ordinary kind with EXL clear, `epc_we` and `exl_set` pulse and `cause_out[31]` equals `in_delay`. `epc` is `cur_pc`, or `cur_pc` − 4 when in a delay slot.
- R10: For an ordinary kind with EXL set, `epc_we` and `exl_set` stay low, `cause_out[31]` keeps `cause_in[31]`, and the code is still written.
- R11: NMI and soft reset pulse `err_epc_we`, `erl_set` and `bev_set`, set `new_pc` to 0xBFC00000, and store the delay-adjusted return PC in `err_epc`. `cause_we`, `epc_we` and `exl_set` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception accepted this cycle |
| exc_kind | input | 5 | Exception kind (encoding in R3) |
| exc_refill | input | 1 | TLB miss with no matching entry |
| cur_pc | input | 32 | PC of the excepting instruction |
| in_delay | input | 1 | Instruction sits in a branch-delay slot |
| st_exl | input | 1 | Status: exception level active |
| st_bev | input | 1 | Status: boot exception vectors |
| st_im | input | 8 | Status: interrupt mask |
| cause_ip | input | 8 | Cause: pending interrupt lines |
| cause_iv | input | 1 | Cause: use the dedicated interrupt vector |
| vec_spacing | input | 5 | Vectored-interrupt spacing field |
| exc_base | input | 32 | Programmed exception base |
| cause_in | input | 32 | Current cause register value |
| take | output | 1 | Pulse: handler PC valid |
| type_err | output | 1 | Pulse: unsupported exception kind |
| new_pc | output | 32 | Handler entry PC |
| epc_we | output | 1 | Pulse: write return PC |
| epc | output | 32 | Return PC |
| err_epc_we | output | 1 | Pulse: write error return PC |
| err_epc | output | 32 | Error return PC |
| cause_we | output | 1 | Pulse: write cause register |
| cause_out | output | 32 | New cause register value |
| exl_set | output | 1 | Pulse: set exception level |
| erl_set | output | 1 | Pulse: set error level |
| bev_set | output | 1 | Pulse: set boot vectors |

## Verification
The bound checker watches, on every cycle, the properties that relate outputs to the request of the previous cycle. These are: results appear only after a request; take and the error pulse never coincide; cause bits outside the code and delay fields are preserved; the written code matches the kind; the return PC carries the delay-slot adjustment; the EXL gate on EPC and BD; and the reset-vector path. The address arithmetic depends on combinations of BEV, IV, spacing, pending-versus-mask priority, refill and EXL. The bench reaches these with directed corners and seeded random requests, and compares them against a separately computed model of the handler PC.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

   localparam int KIND_W = 5;
   localparam int CODE_W = 5;

   typedef enum logic [KIND_W-1:0] {
      EK_INT    = 5'd0,
      EK_MOD    = 5'd1,
      EK_TLBL   = 5'd2,
      EK_TLBS   = 5'd3,
      EK_ADEL   = 5'd4,
      EK_ADES   = 5'd5,
      EK_IBE    = 5'd6,
      EK_DBE    = 5'd7,
      EK_SYS    = 5'd8,
      EK_BRK    = 5'd9,
      EK_RSVD   = 5'd10,
      EK_CPU    = 5'd11,
      EK_OVF    = 5'd12,
      EK_TRAP   = 5'd13,
      EK_FPE    = 5'd15,
      EK_NMI    = 5'd16,
      EK_SRST   = 5'd17,
      EK_RDINH  = 5'd19,
      EK_EXINH  = 5'd20,
      EK_CERR   = 5'd30
   } exc_kind_e;

   typedef enum logic [1:0] {
      EC_GENERAL = 2'd0,
      EC_ERRLVL  = 2'd1,
      EC_BAD     = 2'd2
   } exc_class_e;

   typedef struct packed {
      exc_class_e        cls;
      logic [CODE_W-1:0] code;
      logic              is_tlb;
      logic              is_irq;
      logic              is_cerr;
   } exc_dec_t;

endpackage

// File: rtl/exc_kind_decode.sv
module exc_kind_decode
   import exc_vec_pkg::*;
(
   input  logic [KIND_W-1:0] kind,
   output exc_dec_t          dec
);

   always_comb begin
      dec         = '0;
      dec.cls     = EC_GENERAL;
      dec.code    = CODE_W'(kind);
      case (kind)
         EK_INT:   dec.is_irq  = 1'b1;
         EK_TLBL,
         EK_TLBS:  dec.is_tlb  = 1'b1;
         EK_CERR:  dec.is_cerr = 1'b1;
         EK_MOD, EK_ADEL, EK_ADES, EK_IBE, EK_DBE, EK_SYS, EK_BRK,
         EK_RSVD, EK_CPU, EK_OVF, EK_TRAP, EK_FPE, EK_RDINH,
         EK_EXINH: ;
         EK_NMI,
         EK_SRST: begin
            dec.cls  = EC_ERRLVL;
            dec.code = '0;
         end
         default: begin
            dec.cls  = EC_BAD;
            dec.code = '0;
         end
      endcase
   end

endmodule

// File: rtl/exc_irq_select.sv
module exc_irq_select #(
   parameter int IRQ_N = 8,
   localparam int IDX_W = $clog2(IRQ_N)
) (
   input  logic [IRQ_N-1:0] pending,
   input  logic [IRQ_N-1:0] enable,
   output logic [IDX_W-1:0] idx
);

   logic [IRQ_N-1:0] act;
   logic [IRQ_N-1:0] top;

   assign act = pending & enable;

   // One-hot marker of the highest active line.
   for (genvar gi = 0; gi < IRQ_N; gi++) begin : g_top
      if (gi == IRQ_N - 1) begin : g_msb
         assign top[gi] = act[gi];
      end else begin : g_low
         assign top[gi] = act[gi] & ~(|act[IRQ_N-1:gi+1]);
      end
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < IRQ_N; i++) begin
         if (top[i]) idx = idx | IDX_W'(i);
      end
   end

endmodule

// File: rtl/exc_vec_offset.sv
module exc_vec_offset
   import exc_vec_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int IRQ_N       = 8,
   parameter int SPACE_W     = 5,
   parameter int SPACE_SHIFT = 5,
   parameter logic [ADDR_W-1:0] OFF_DEFAULT  = 'h180,
   parameter logic [ADDR_W-1:0] OFF_REFILL   = 'h000,
   parameter logic [ADDR_W-1:0] OFF_IRQ      = 'h200,
   parameter logic [ADDR_W-1:0] OFF_CERR_BOOT = 'h100,
   parameter logic [ADDR_W-1:0] OFF_CERR_RUN  = 'h2000_0100
) (
   input  exc_dec_t           dec,
   input  logic               refill,
   input  logic               exl,
   input  logic               bev,
   input  logic               iv,
   input  logic [SPACE_W-1:0] spacing,
   input  logic [IRQ_N-1:0]   pending,
   input  logic [IRQ_N-1:0]   enable,
   output logic [ADDR_W-1:0]  offset
);

   localparam int IDX_W = $clog2(IRQ_N);

   logic [IDX_W-1:0]  vec_idx;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] irq_off;

   exc_irq_select #(.IRQ_N(IRQ_N)) u_sel (
      .pending (pending),
      .enable  (enable),
      .idx     (vec_idx)
   );

   assign step    = ADDR_W'(spacing) << SPACE_SHIFT;
   assign irq_off = OFF_IRQ + ADDR_W'(vec_idx) * step;

   always_comb begin
      offset = OFF_DEFAULT;
      if (dec.is_cerr) begin
         offset = bev ? OFF_CERR_BOOT : OFF_CERR_RUN;
      end else if (dec.is_tlb && refill && !exl) begin
         offset = OFF_REFILL;
      end else if (dec.is_irq && iv) begin
         if (bev || (spacing == '0)) offset = OFF_IRQ;
         else                        offset = irq_off;
      end
   end

endmodule

// File: rtl/exc_ret_pc.sv
module exc_ret_pc #(
   parameter int ADDR_W     = 32,
   parameter int SLOT_BYTES = 4
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic              in_delay,
   output logic [ADDR_W-1:0] ret_pc
);

   localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SLOT_BYTES);

   assign ret_pc = in_delay ? (pc - SLOT) : pc;

endmodule

// File: rtl/exc_vec_ctrl.sv
module exc_vec_ctrl
   import exc_vec_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IRQ_N      = 8,
   parameter int SPACE_W    = 5,
   parameter int CAUSE_W    = 32,
   parameter int CODE_LSB   = 2,
   parameter int BD_BIT     = 31,
   parameter int BASE_ALIGN = 10,
   parameter int SLOT_BYTES = 4,
   parameter logic [ADDR_W-1:0] BOOT_BASE = 'hBFC0_0200,
   parameter logic [ADDR_W-1:0] RESET_VEC = 'hBFC0_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_valid,
   input  logic [KIND_W-1:0]  exc_kind,
   input  logic               exc_refill,
   input  logic [ADDR_W-1:0]  cur_pc,
   input  logic               in_delay,
   input  logic               st_exl,
   input  logic               st_bev,
   input  logic [IRQ_N-1:0]   st_im,
   input  logic [IRQ_N-1:0]   cause_ip,
   input  logic               cause_iv,
   input  logic [SPACE_W-1:0] vec_spacing,
   input  logic [ADDR_W-1:0]  exc_base,
   input  logic [CAUSE_W-1:0] cause_in,
   output logic               take,
   output logic               type_err,
   output logic [ADDR_W-1:0]  new_pc,
   output logic               epc_we,
   output logic [ADDR_W-1:0]  epc,
   output logic               err_epc_we,
   output logic [ADDR_W-1:0]  err_epc,
   output logic               cause_we,
   output logic [CAUSE_W-1:0] cause_out,
   output logic               exl_set,
   output logic               erl_set,
   output logic               bev_set
);

   if (ADDR_W < 32) begin : g_chk_addr
      $error("exc_vec_ctrl: ADDR_W must be at least 32");
   end
   if (IRQ_N < 2) begin : g_chk_irq
      $error("exc_vec_ctrl: IRQ_N must be at least 2");
   end
   if (CODE_LSB + CODE_W > CAUSE_W || BD_BIT >= CAUSE_W) begin : g_chk_cause
      $error("exc_vec_ctrl: cause field positions exceed CAUSE_W");
   end
   if (BD_BIT >= CODE_LSB && BD_BIT < CODE_LSB + CODE_W) begin : g_chk_overlap
      $error("exc_vec_ctrl: delay bit overlaps the code field");
   end
   if (BASE_ALIGN < 1 || BASE_ALIGN >= ADDR_W) begin : g_chk_align
      $error("exc_vec_ctrl: BASE_ALIGN out of range");
   end

   exc_dec_t          dec;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] ret_pc;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] vec_pc;
   logic [CAUSE_W-1:0] cause_nx;

   exc_kind_decode u_dec (
      .kind (exc_kind),
      .dec  (dec)
   );

   exc_vec_offset #(
      .ADDR_W  (ADDR_W),
      .IRQ_N   (IRQ_N),
      .SPACE_W (SPACE_W)
   ) u_off (
      .dec     (dec),
      .refill  (exc_refill),
      .exl     (st_exl),
      .bev     (st_bev),
      .iv      (cause_iv),
      .spacing (vec_spacing),
      .pending (cause_ip),
      .enable  (st_im),
      .offset  (offset)
   );

   exc_ret_pc #(
      .ADDR_W     (ADDR_W),
      .SLOT_BYTES (SLOT_BYTES)
   ) u_ret (
      .pc       (cur_pc),
      .in_delay (in_delay),
      .ret_pc   (ret_pc)
   );

   assign base   = st_bev ? BOOT_BASE
                          : {exc_base[ADDR_W-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}};
   assign vec_pc = base + offset;

   always_comb begin
      cause_nx = cause_in;
      cause_nx[CODE_LSB +: CODE_W] = dec.code;
      if (!st_exl) cause_nx[BD_BIT] = in_delay;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take       <= 1'b0;
         type_err   <= 1'b0;
         new_pc     <= '0;
         epc_we     <= 1'b0;
         epc        <= '0;
         err_epc_we <= 1'b0;
         err_epc    <= '0;
         cause_we   <= 1'b0;
         cause_out  <= '0;
         exl_set    <= 1'b0;
         erl_set    <= 1'b0;
         bev_set    <= 1'b0;
      end else begin
         take       <= 1'b0;
         type_err   <= 1'b0;
         epc_we     <= 1'b0;
         err_epc_we <= 1'b0;
         cause_we   <= 1'b0;
         exl_set    <= 1'b0;
         erl_set    <= 1'b0;
         bev_set    <= 1'b0;
         if (exc_valid) begin
            case (dec.cls)
               EC_GENERAL: begin
                  take      <= 1'b1;
                  new_pc    <= vec_pc;
                  cause_we  <= 1'b1;
                  cause_out <= cause_nx;
                  if (!st_exl) begin
                     epc_we  <= 1'b1;
                     epc     <= ret_pc;
                     exl_set <= 1'b1;
                  end
               end
               EC_ERRLVL: begin
                  take       <= 1'b1;
                  new_pc     <= RESET_VEC;
                  err_epc_we <= 1'b1;
                  err_epc    <= ret_pc;
                  erl_set    <= 1'b1;
                  bev_set    <= 1'b1;
               end
               default: type_err <= 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/exc_vec_ctrl_chk.sv
module exc_vec_ctrl_chk
   import exc_vec_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IRQ_N      = 8,
   parameter int SPACE_W    = 5,
   parameter int CAUSE_W    = 32,
   parameter int CODE_LSB   = 2,
   parameter int BD_BIT     = 31,
   parameter int SLOT_BYTES = 4,
   parameter logic [ADDR_W-1:0] RESET_VEC = 'hBFC0_0000
) (
   input logic               clk,
   input logic               rst_n,
   input logic               exc_valid,
   input logic [KIND_W-1:0]  exc_kind,
   input logic [ADDR_W-1:0]  cur_pc,
   input logic               in_delay,
   input logic               st_exl,
   input logic [CAUSE_W-1:0] cause_in,
   input logic               take,
   input logic               type_err,
   input logic [ADDR_W-1:0]  new_pc,
   input logic               epc_we,
   input logic [ADDR_W-1:0]  epc,
   input logic               err_epc_we,
   input logic               cause_we,
   input logic [CAUSE_W-1:0] cause_out,
   input logic               exl_set,
   input logic               erl_set,
   input logic               bev_set
);

   localparam logic [CAUSE_W-1:0] FIELD_M = CAUSE_W'((2**CODE_W) - 1) << CODE_LSB;
   localparam logic [CAUSE_W-1:0] BD_M    = CAUSE_W'(1) << BD_BIT;
   localparam logic [CAUSE_W-1:0] KEEP_M  = ~(FIELD_M | BD_M);
   localparam logic [ADDR_W-1:0]  SLOT    = ADDR_W'(SLOT_BYTES);

   a_r2_from_request: assert property (@(posedge clk) disable iff (!rst_n)
      (take || type_err) |-> $past(exc_valid));

   a_r2_take_or_err: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !type_err);

   a_r2_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      type_err |-> !(epc_we || err_epc_we || cause_we || exl_set || erl_set || bev_set));

   a_r3_code_written: assert property (@(posedge clk) disable iff (!rst_n)
      cause_we |-> (cause_out[CODE_LSB +: CODE_W] == CODE_W'($past(exc_kind))));

   a_r4_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
      cause_we |-> ((cause_out & KEEP_M) == ($past(cause_in) & KEEP_M)));

   a_r9_epc_value: assert property (@(posedge clk) disable iff (!rst_n)
      epc_we |-> (epc == ($past(cur_pc) - ($past(in_delay) ? SLOT : '0))));

   a_r9_bd_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_we && !$past(st_exl)) |-> (cause_out[BD_BIT] == $past(in_delay)));

   a_r10_exl_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (take && $past(st_exl)) |-> !(epc_we || exl_set));

   a_r10_bd_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_we && $past(st_exl)) |-> (cause_out[BD_BIT] == $past(cause_in[BD_BIT])));

   a_r11_reset_path: assert property (@(posedge clk) disable iff (!rst_n)
      erl_set |-> (new_pc == RESET_VEC && bev_set && err_epc_we && !cause_we && !epc_we));

endmodule

bind exc_vec_ctrl exc_vec_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .IRQ_N      (IRQ_N),
   .SPACE_W    (SPACE_W),
   .CAUSE_W    (CAUSE_W),
   .CODE_LSB   (CODE_LSB),
   .BD_BIT     (BD_BIT),
   .SLOT_BYTES (SLOT_BYTES),
   .RESET_VEC  (RESET_VEC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .exc_valid  (exc_valid),
   .exc_kind   (exc_kind),
   .cur_pc     (cur_pc),
   .in_delay   (in_delay),
   .st_exl     (st_exl),
   .cause_in   (cause_in),
   .take       (take),
   .type_err   (type_err),
   .new_pc     (new_pc),
   .epc_we     (epc_we),
   .epc        (epc),
   .err_epc_we (err_epc_we),
   .cause_we   (cause_we),
   .cause_out  (cause_out),
   .exl_set    (exl_set),
   .erl_set    (erl_set),
   .bev_set    (bev_set)
);

// File: tb/test_exc_vec_ctrl.sv
`timescale 1ns/1ps
module test_exc_vec_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid = 1'b0;
   logic [4:0]  exc_kind = '0;
   logic        exc_refill = 1'b0;
   logic [31:0] cur_pc = '0;
   logic        in_delay = 1'b0;
   logic        st_exl = 1'b0;
   logic        st_bev = 1'b0;
   logic [7:0]  st_im = '0;
   logic [7:0]  cause_ip = '0;
   logic        cause_iv = 1'b0;
   logic [4:0]  vec_spacing = '0;
   logic [31:0] exc_base = '0;
   logic [31:0] cause_in = '0;
   logic        take, type_err, epc_we, err_epc_we, cause_we;
   logic        exl_set, erl_set, bev_set;
   logic [31:0] new_pc, epc, err_epc, cause_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   exc_vec_ctrl i_exc_vec_ctrl (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_kind(exc_kind),
      .exc_refill(exc_refill), .cur_pc(cur_pc), .in_delay(in_delay),
      .st_exl(st_exl), .st_bev(st_bev), .st_im(st_im), .cause_ip(cause_ip),
      .cause_iv(cause_iv), .vec_spacing(vec_spacing), .exc_base(exc_base),
      .cause_in(cause_in), .take(take), .type_err(type_err), .new_pc(new_pc),
      .epc_we(epc_we), .epc(epc), .err_epc_we(err_epc_we), .err_epc(err_epc),
      .cause_we(cause_we), .cause_out(cause_out), .exl_set(exl_set),
      .erl_set(erl_set), .bev_set(bev_set)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit is_known(input logic [4:0] k);
      return (k <= 5'd13) || k == 5'd15 || k == 5'd16 || k == 5'd17 ||
             k == 5'd19 || k == 5'd20 || k == 5'd30;
   endfunction

   function automatic logic [31:0] ref_offset(input logic [4:0] k, input bit refill,
         input bit exl, input bit bev, input bit iv, input logic [4:0] sp,
         input logic [7:0] ip, input logic [7:0] im);
      logic [7:0] act;
      int v;
      if (k == 5'd30) return bev ? 32'h100 : 32'h2000_0100;
      if ((k == 5'd2 || k == 5'd3) && refill && !exl) return 32'h0;
      if (k == 5'd0 && iv) begin
         if (bev || sp == 0) return 32'h200;
         act = ip & im;
         v = 0;
         for (int i = 7; i >= 0; i--) begin
            if (act[i]) begin v = i; break; end
         end
         return 32'h200 + 32'(v) * 32'(sp) * 32;
      end
      return 32'h180;
   endfunction

   function automatic string req_of(input logic [4:0] k, input bit refill);
      if (k == 5'd0) return "R7";
      if (k == 5'd30) return "R8";
      if ((k == 5'd2 || k == 5'd3) && refill) return "R6";
      return "R5";
   endfunction

   task automatic fire(input logic [4:0] k, input bit refill, input logic [31:0] pc,
         input bit dly, input bit exl, input bit bev, input logic [7:0] im,
         input logic [7:0] ip, input bit iv, input logic [4:0] sp,
         input logic [31:0] base, input logic [31:0] cin);
      logic [31:0] exp_pc, exp_ret, exp_cause;
      bit known, errlvl;
      @(negedge clk);
      exc_kind = k; exc_refill = refill; cur_pc = pc; in_delay = dly;
      st_exl = exl; st_bev = bev; st_im = im; cause_ip = ip; cause_iv = iv;
      vec_spacing = sp; exc_base = base; cause_in = cin; exc_valid = 1'b1;
      @(negedge clk);
      exc_valid = 1'b0;
      known   = is_known(k);
      errlvl  = (k == 5'd16 || k == 5'd17);
      exp_ret = dly ? pc - 32'd4 : pc;
      if (!known) begin
         chk("R2", "type_err", 32'(type_err), 32'd1);
         chk("R2", "take(bad)", 32'(take), 32'd0);
         chk("R2", "strobes(bad)",
             32'({epc_we, err_epc_we, cause_we, exl_set, erl_set, bev_set}), 32'd0);
      end else if (errlvl) begin
         chk("R2", "take", 32'(take), 32'd1);
         chk("R11", "new_pc", new_pc, 32'hBFC0_0000);
         chk("R11", "err_epc", err_epc, exp_ret);
         chk("R11", "strobes",
             32'({epc_we, err_epc_we, cause_we, exl_set, erl_set, bev_set}), 32'b010011);
      end else begin
         exp_pc = (bev ? 32'hBFC0_0200 : {base[31:10], 10'b0}) +
                  ref_offset(k, refill, exl, bev, iv, sp, ip, im);
         exp_cause = cin;
         exp_cause[6:2] = k;
         if (!exl) exp_cause[31] = dly;
         chk("R2", "take", 32'(take), 32'd1);
         chk("R2", "type_err", 32'(type_err), 32'd0);
         chk(req_of(k, refill), "new_pc", new_pc, exp_pc);
         chk("R3", "cause_we", 32'(cause_we), 32'd1);
         chk("R3", "code", 32'(cause_out[6:2]), 32'(k));
         chk("R4", "cause_out", cause_out, exp_cause);
         if (!exl) begin
            chk("R9", "epc_we/exl_set", 32'({epc_we, exl_set}), 32'b11);
            chk("R9", "epc", epc, exp_ret);
         end else begin
            chk("R10", "epc_we/exl_set", 32'({epc_we, exl_set}), 32'b00);
         end
         chk("R11", "erl/bev/eepc", 32'({erl_set, bev_set, err_epc_we}), 32'd0);
      end
   endtask

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "strobes at reset",
          32'({take, type_err, epc_we, err_epc_we, cause_we, exl_set, erl_set, bev_set}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "strobes after reset",
          32'({take, type_err, epc_we, err_epc_we, cause_we, exl_set, erl_set, bev_set}), 32'd0);

      // R5: default offset, run-time base with low bits dropped
      fire(5'd8, 0, 32'h8000_1000, 0, 0, 0, 8'h00, 8'h00, 0, 5'd0, 32'h8000_03FF, 32'h0000_FF00);
      // R2: pulse lasts one cycle
      @(negedge clk);
      chk("R2", "take one cycle", 32'(take), 32'd0);
      // R5: boot base
      fire(5'd12, 0, 32'h0040_0000, 0, 0, 1, 8'h00, 8'h00, 0, 5'd0, 32'h1234_5678, 32'h0);
      // R6: refill with EXL clear, then set
      fire(5'd2, 1, 32'h0040_0010, 0, 0, 0, 8'h00, 8'h00, 0, 5'd0, 32'h8000_0000, 32'h0);
      fire(5'd3, 1, 32'h0040_0014, 0, 1, 0, 8'h00, 8'h00, 0, 5'd0, 32'h8000_0000, 32'h8000_0000);
      // R7: IV clear, BEV with IV, spacing zero, vectored priority, none pending
      fire(5'd0, 0, 32'h0040_0020, 0, 0, 0, 8'hFF, 8'h80, 0, 5'd4, 32'h8000_0000, 32'h0);
      fire(5'd0, 0, 32'h0040_0020, 0, 0, 1, 8'hFF, 8'h80, 1, 5'd4, 32'h8000_0000, 32'h0);
      fire(5'd0, 0, 32'h0040_0020, 0, 0, 0, 8'hFF, 8'h80, 1, 5'd0, 32'h8000_0000, 32'h0);
      fire(5'd0, 0, 32'h0040_0020, 0, 0, 0, 8'h7F, 8'hA4, 1, 5'd1, 32'h8000_0000, 32'h0);
      fire(5'd0, 0, 32'h0040_0020, 0, 0, 0, 8'hFF, 8'hA4, 1, 5'd31, 32'h8000_0000, 32'h0);
      fire(5'd0, 0, 32'h0040_0020, 0, 0, 0, 8'h0F, 8'hF0, 1, 5'd2, 32'h8000_0000, 32'h0);
      // R8: cache error both placements
      fire(5'd30, 0, 32'h0040_0030, 0, 0, 1, 8'h00, 8'h00, 0, 5'd0, 32'h8000_0000, 32'h0);
      fire(5'd30, 0, 32'h0040_0030, 0, 0, 0, 8'h00, 8'h00, 0, 5'd0, 32'h9000_0400, 32'h0);
      // R9/R10: delay slot with EXL clear and set
      fire(5'd4, 0, 32'h0040_0044, 1, 0, 0, 8'h00, 8'h00, 0, 5'd0, 32'h8000_0000, 32'h0);
      fire(5'd5, 0, 32'h0040_0048, 1, 1, 0, 8'h00, 8'h00, 0, 5'd0, 32'h8000_0000, 32'h0000_0000);
      // R11: NMI and soft reset
      fire(5'd16, 0, 32'h0040_0050, 1, 0, 0, 8'h00, 8'h00, 0, 5'd0, 32'h8000_0000, 32'h0);
      fire(5'd17, 0, 32'h0040_0054, 0, 1, 0, 8'h00, 8'h00, 0, 5'd0, 32'h8000_0000, 32'h0);
      // R2: unsupported kinds
      fire(5'd14, 0, 32'h0040_0060, 0, 0, 0, 8'h00, 8'h00, 0, 5'd0, 32'h8000_0000, 32'h0);
      fire(5'd31, 0, 32'h0040_0064, 0, 0, 0, 8'h00, 8'h00, 0, 5'd0, 32'h8000_0000, 32'h0);

      for (int n = 0; n < 600; n++) begin
         logic [4:0] k;
         k = 5'($urandom_range(0, 31));
         fire(k, 1'($urandom), $urandom & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom),
              1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
              5'($urandom), $urandom, $urandom);
      end

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule